// File: doc/BRIEF.md
# Flash command decoder

This block sits on the bus side of a byte-wide flash memory model and reads the bytes that the host writes to the command register. It keeps a read mode that decides where each read cycle's data comes from. In normal operation, reads return array data. After an identifier command, reads return fixed identification bytes. While an erase is running, reads return a status byte whose bit 6 flips on every read strobe, so the host can poll for completion.

An erase takes two command writes in a row. A chip erase is the chip-erase byte written twice. A block erase is a setup byte followed by a confirm byte, and the address of the confirm write selects the block. When the erase is confirmed, the decoder sends a one-cycle start pulse to an external erase sequencer, together with the chip/block choice and the block index. The sequencer returns a done pulse when it finishes, and the decoder then goes back to array reads by itself.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in array mode: `rd_data` equals `array_data` and `erase_start` is 0.
- R2: A command write of 00h selects array mode, so reads return `array_data`.
- R3: A command write of 90h selects identifier mode. A read at address 0 returns `MFR_CODE` (default C2h), a read at address 1 returns `DEV_CODE` (default 2Ah), and a read at any other address returns 00h.
- R4: A single write of 30h only stages a chip erase. It gives no start pulse, and reads still return `array_data`.
- R5: A write of 30h while a chip erase is staged starts the erase. In the cycle after that write's clock edge, `erase_start` is 1 and `erase_blk_mode` is 0.
- R6: While an erase is staged, a write of any byte that is not the matching confirm byte cancels the staging without a start pulse. That byte is then decoded as a new command.
- R7: A write of 20h stages a block erase. A following write of D0h starts it: in the next cycle `erase_start` is 1, `erase_blk_mode` is 1, and `erase_blk_idx` equals the top `BLK_W` bits of the confirm write's address.
- R8: While an erase runs, `rd_data` is the status byte {0, toggle, 000000}. The toggle starts at 0 and flips after each cycle with `rd_en` high. Command writes are ignored during this time.
- R9: An `eng_done` pulse during an erase returns the decoder to array mode in the next cycle.
- R10: `erase_start` is high for exactly one cycle. `erase_blk_mode` and `erase_blk_idx` stay stable while the erase runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the command write |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Read strobe; advances the status toggle |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Data from the array storage at `rd_addr` |
| rd_data | output | 8 | Read data returned to the bus |
| erase_start | output | 1 | One-cycle start pulse to the erase sequencer |
| erase_blk_mode | output | 1 | 1 = block erase, 0 = chip erase |
| erase_blk_idx | output | BLK_W | Block selected for a block erase |
| eng_done | input | 1 | Erase sequencer completion pulse |

## Verification
A command write takes effect at the clock edge that captures it. Reads are combinational from the mode, so the new read source can be seen in the cycle after the write. `erase_start` and the erase select outputs are registered at that same edge and are also seen in the next cycle. The status toggle flips on the edge that ends a strobed read, so each strobed read shows the value from before its own flip. The bench drives inputs just after the falling edge and compares each queued expectation a little later in the same low phase, before the next rising edge. This puts every check in exactly the cycle the latencies above predict.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ        = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_IDENT       = 8'h90;
    localparam logic [BYTE_W-1:0] CMD_CHIP        = 8'h30;
    localparam logic [BYTE_W-1:0] CMD_BLK_SETUP   = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_BLK_CONFIRM = 8'hD0;

    typedef enum logic [2:0] {
        M_ARRAY    = 3'd0,
        M_IDENT    = 3'd1,
        M_CHIP_STG = 3'd2,
        M_BLK_STG  = 3'd3,
        M_ERASING  = 3'd4
    } mode_e;

    function automatic mode_e decode_fresh(input logic [BYTE_W-1:0] cmd);
        case (cmd)
            CMD_IDENT:     decode_fresh = M_IDENT;
            CMD_CHIP:      decode_fresh = M_CHIP_STG;
            CMD_BLK_SETUP: decode_fresh = M_BLK_STG;
            default:       decode_fresh = M_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BLK_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                eng_done,
    output mode_e               mode,
    output logic                erase_start,
    output logic                erase_blk_mode,
    output logic [BLK_W-1:0]    erase_blk_idx
);

    typedef struct packed {
        mode_e            mode;
        logic             start;
        logic             blk_mode;
        logic [BLK_W-1:0] blk_idx;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        case (st_q.mode)
            M_ERASING: begin
                if (eng_done) begin
                    st_d.mode = M_ARRAY;
                end
            end
            M_CHIP_STG: begin
                if (wr_en) begin
                    if (wr_data == CMD_CHIP) begin
                        st_d.mode     = M_ERASING;
                        st_d.start    = 1'b1;
                        st_d.blk_mode = 1'b0;
                        st_d.blk_idx  = '0;
                    end else begin
                        st_d.mode = decode_fresh(wr_data);
                    end
                end
            end
            M_BLK_STG: begin
                if (wr_en) begin
                    if (wr_data == CMD_BLK_CONFIRM) begin
                        st_d.mode     = M_ERASING;
                        st_d.start    = 1'b1;
                        st_d.blk_mode = 1'b1;
                        st_d.blk_idx  = wr_addr[ADDR_W-1 -: BLK_W];
                    end else begin
                        st_d.mode = decode_fresh(wr_data);
                    end
                end
            end
            default: begin
                if (wr_en) begin
                    st_d.mode = decode_fresh(wr_data);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_ARRAY, start: 1'b0, blk_mode: 1'b0, blk_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode           = st_q.mode;
    assign erase_start    = st_q.start;
    assign erase_blk_mode = st_q.blk_mode;
    assign erase_blk_idx  = st_q.blk_idx;

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
    import flash_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  rd_en,
    output logic  tgl
);

    logic tgl_d, tgl_q;

    always_comb begin
        tgl_d = 1'b0;
        if (mode == M_ERASING) begin
            tgl_d = rd_en ? ~tgl_q : tgl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= tgl_d;
        end
    end

    assign tgl = tgl_q;

endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 18,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'hC2,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'h2A
) (
    input  mode_e               mode,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]   array_data,
    input  logic                tgl,
    output logic [BYTE_W-1:0]   rd_data
);

    localparam logic [ADDR_W-1:0] ID_ADDR_MFR = '0;
    localparam logic [ADDR_W-1:0] ID_ADDR_DEV = ADDR_W'(1);

    logic [BYTE_W-1:0] id_byte;
    logic [BYTE_W-1:0] status_byte;

    always_comb begin
        if (rd_addr == ID_ADDR_MFR) begin
            id_byte = MFR_CODE;
        end else if (rd_addr == ID_ADDR_DEV) begin
            id_byte = DEV_CODE;
        end else begin
            id_byte = '0;
        end
        status_byte    = '0;
        status_byte[6] = tgl;
    end

    always_comb begin
        case (mode)
            M_IDENT:   rd_data = id_byte;
            M_ERASING: rd_data = status_byte;
            default:   rd_data = array_data;
        endcase
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int          BLK_W    = 2,
    parameter logic [7:0]  MFR_CODE = 8'hC2,
    parameter logic [7:0]  DEV_CODE = 8'h2A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [7:0]          array_data,
    output logic [7:0]          rd_data,
    output logic                erase_start,
    output logic                erase_blk_mode,
    output logic [BLK_W-1:0]    erase_blk_idx,
    input  logic                eng_done
);

    mode_e mode;
    logic  tgl;

    flash_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .eng_done       (eng_done),
        .mode           (mode),
        .erase_start    (erase_start),
        .erase_blk_mode (erase_blk_mode),
        .erase_blk_idx  (erase_blk_idx)
    );

    flash_cmd_status i_status (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .rd_en (rd_en),
        .tgl   (tgl)
    );

    flash_cmd_rdmux #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) i_rdmux (
        .mode       (mode),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .tgl        (tgl),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int          BLK_W    = 2,
    parameter logic [7:0]  MFR_CODE = 8'hC2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              erase_start,
    input logic              erase_blk_mode,
    input logic [BLK_W-1:0]  erase_blk_idx,
    input logic              eng_done,
    input mode_e             mode
);

    logic [BLK_W-1:0] wr_blk;
    logic             erasing;

    assign wr_blk  = wr_addr[ADDR_W-1 -: BLK_W];
    assign erasing = (mode == M_ERASING);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start); // R10

    AST_CHIP_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start && !erase_blk_mode) |-> ($past(wr_en) && $past(wr_data) == CMD_CHIP)); // R5

    AST_BLK_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start && erase_blk_mode) |->
            ($past(wr_en) && $past(wr_data) == CMD_BLK_CONFIRM && erase_blk_idx == $past(wr_blk))); // R7

    AST_DONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing && eng_done) |=> (mode == M_ARRAY)); // R9

    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing && !eng_done) |=> erasing); // R8

    AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        erasing |-> (rd_data[7] == 1'b0 && rd_data[5:0] == 6'd0)); // R8

    AST_ID_MFR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDENT && rd_addr == '0) |-> rd_data == MFR_CODE); // R3

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing && $past(erasing)) |-> ($stable(erase_blk_idx) && $stable(erase_blk_mode))); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .MFR_CODE (MFR_CODE)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .rd_addr        (rd_addr),
    .rd_data        (rd_data),
    .erase_start    (erase_start),
    .erase_blk_mode (erase_blk_mode),
    .erase_blk_idx  (erase_blk_idx),
    .eng_done       (eng_done),
    .mode           (mode)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int ADDR_W = 18;
    localparam int BLK_W  = 2;

    localparam int K_RD    = 0;
    localparam int K_START = 1;
    localparam int K_BMODE = 2;
    localparam int K_BIDX  = 3;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        array_data;
    logic [7:0]        rd_data;
    logic              erase_start;
    logic              erase_blk_mode;
    logic [BLK_W-1:0]  erase_blk_idx;
    logic              eng_done = 1'b0;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_err = 0;
    bit    done_run = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] arr_model(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign array_data = arr_model(rd_addr);

    flash_cmd_decoder #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) i_flash_cmd_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_en          (rd_en),
        .rd_addr        (rd_addr),
        .array_data     (array_data),
        .rd_data        (rd_data),
        .erase_start    (erase_start),
        .erase_blk_mode (erase_blk_mode),
        .erase_blk_idx  (erase_blk_idx),
        .eng_done       (eng_done)
    );

    task automatic push(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        eng_done = 1'b0;
    endtask

    // one write cycle, then a check of the start pulse in the following cycle
    task automatic cmd_write(input logic [7:0] d, input logic [ADDR_W-1:0] a,
                             input logic exp_start, input string tag);
        step();
        wr_en   = 1'b1;
        wr_data = d;
        wr_addr = a;
        step();
        push(K_START, {7'd0, exp_start}, tag);
    endtask

    task automatic rd_check(input logic [ADDR_W-1:0] a, input logic strobe,
                            input logic [7:0] exp, input string tag);
        step();
        rd_addr = a;
        rd_en   = strobe;
        push(K_RD, exp, tag);
    endtask

    task automatic pulse_done();
        step();
        eng_done = 1'b1;
    endtask

    // monitor: compares queued expectations in the low phase
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb_q.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = rd_data;
                    K_START: act = {7'd0, erase_start};
                    K_BMODE: act = {7'd0, erase_blk_mode};
                    default: act = {{(8-BLK_W){1'b0}}, erase_blk_idx};
                endcase
                n_vec++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        rd_check(18'h00005, 1'b0, arr_model(18'h00005), "R1 array after reset");
        push(K_START, 8'h00, "R1 no start after reset");

        // R3: identifier reads
        cmd_write(8'h90, '0, 1'b0, "R3 no start on ident");
        rd_check(18'h00000, 1'b0, 8'hC2, "R3 mfr code");
        rd_check(18'h00001, 1'b0, 8'h2A, "R3 dev code");
        rd_check(18'h00007, 1'b0, 8'h00, "R3 other addr");

        // R2: back to array
        cmd_write(8'h00, '0, 1'b0, "R2 no start");
        rd_check(18'h00003, 1'b0, arr_model(18'h00003), "R2 array read");

        // R4: single stage
        cmd_write(8'h30, '0, 1'b0, "R4 stage no start");
        rd_check(18'h00002, 1'b0, arr_model(18'h00002), "R4 array while staged");

        // R6: cancel by ident, decoded fresh
        cmd_write(8'h90, '0, 1'b0, "R6 cancel no start");
        rd_check(18'h00000, 1'b0, 8'hC2, "R6 fresh decode ident");

        // R5: chip erase
        cmd_write(8'h30, '0, 1'b0, "R5 first stage");
        cmd_write(8'h30, '0, 1'b1, "R5 start pulse");
        push(K_BMODE, 8'h00, "R5 chip select");

        // R8: status with toggling bit 6; R10 pulse width
        rd_check(18'h00000, 1'b1, 8'h00, "R8 status read 1");
        push(K_START, 8'h00, "R10 start single cycle");
        rd_check(18'h00001, 1'b1, 8'h40, "R8 status read 2");
        rd_check(18'h00000, 1'b1, 8'h00, "R8 status read 3");
        cmd_write(8'h00, '0, 1'b0, "R8 write ignored no start");
        rd_check(18'h00004, 1'b0, 8'h40, "R8 write ignored status kept");

        // R9: done returns to array
        pulse_done();
        rd_check(18'h00006, 1'b0, arr_model(18'h00006), "R9 array after done");

        // R7: block erase with index from confirm address
        cmd_write(8'h20, '0, 1'b0, "R7 block stage");
        cmd_write(8'hD0, 18'h2ABCD, 1'b1, "R7 block start");
        push(K_BMODE, 8'h01, "R7 block select");
        push(K_BIDX, 8'h02, "R7 block index");
        rd_check(18'h00000, 1'b0, 8'h00, "R8 block status");
        push(K_BIDX, 8'h02, "R10 index held");
        push(K_BMODE, 8'h01, "R10 block mode held");
        pulse_done();
        rd_check(18'h00009, 1'b0, arr_model(18'h00009), "R9 array after block done");

        // R6: block stage cancelled by 00h, and chip byte then stages freshly
        cmd_write(8'h20, '0, 1'b0, "R6 block stage");
        cmd_write(8'h00, '0, 1'b0, "R6 block cancel");
        rd_check(18'h0000A, 1'b0, arr_model(18'h0000A), "R6 array after cancel");
        cmd_write(8'h20, '0, 1'b0, "R6 block stage again");
        cmd_write(8'h30, '0, 1'b0, "R6 chip byte cancels block");
        cmd_write(8'h30, '0, 1'b1, "R6 fresh chip stage confirms");
        push(K_BMODE, 8'h00, "R6 chip mode after fresh stage");
        pulse_done();
        rd_check(18'h0000B, 1'b0, arr_model(18'h0000B), "R9 array after chip done");

        step();
        step();
        done_run = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule